// File: doc/BRIEF.md
# CAN Remote Request Responder

This block handles remote-frame behaviour for a bank of CAN message buffers. Each buffer holds a 4-bit state code, an identifier, an identifier-extension flag (IDE), a remote flag and a data length. Software or a host agent loads buffers through a configuration write port. The block produces a pending-transmit vector, and an arbitration engine outside the block consumes it. A read port shows any one buffer's descriptor to that engine.

When the receive path reports a frame with its remote flag set, the block scans every buffer once, one buffer per cycle. The scan looks for answer buffers whose identifier and IDE match the request exactly; the acceptance masks play no part. The lowest-indexed hit is marked pending. The response takes its remote flag and length from the buffer, and the request frame itself is never stored anywhere. When a buffer that was sent as a remote request reports completion, it turns into an empty receive buffer and keeps its identifier.

Top module: `can_remote_responder`

## Requirements
- R1: After reset every buffer reads code 0000 with zero fields, and the pending vector is all zero.
- R2: A configuration write of code 1100 (transmit once) sets that buffer's pending bit. A write of any other code clears it.
- R3: A transmit completion for a buffer in code 1100 with its remote flag set changes the code to 0100 (receive empty), keeps the identifier, and clears the pending bit.
- R4: A transmit completion for a buffer in code 1100 with its remote flag clear changes the code to 1000 (transmit idle).
- R5: A remote request sampled at clock edge E0 matches only buffers in code 1010 (answer). The matching buffer's pending bit rises after edge E0+NUM_BUF and not earlier.
- R6: A remote request that matches nothing changes no pending bit and no buffer, including receive buffers that hold the same identifier.
- R7: When several answer buffers match, only the lowest-indexed one becomes pending.
- R8: A triggered buffer keeps its own remote flag, which selects the response kind, and its own data length.
- R9: A received frame with its remote flag clear has no effect.
- R10: A remote request that arrives during a scan is held in a one-entry register and scanned right after the current scan. A further request that arrives while the holder is full is dropped.
- R11: When a scan hit and a transmit completion fall on the same buffer in the same cycle, the pending bit stays set. A completion on its own clears the bit and leaves an answer buffer in code 1010.
- R12: A request with IDE=1 compares all 29 identifier bits. A request with IDE=0 compares only bits 10:0. The IDE bits must be equal in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Buffer configuration write strobe |
| cfg_idx_i | input | IDX_W | Buffer index to write |
| cfg_code_i | input | 4 | State code to write |
| cfg_id_i | input | 29 | Identifier to write |
| cfg_ide_i | input | 1 | Extended-identifier flag to write |
| cfg_rtr_i | input | 1 | Remote flag to write |
| cfg_dlc_i | input | 4 | Data length to write |
| rx_valid_i | input | 1 | Received frame descriptor strobe |
| rx_id_i | input | 29 | Received identifier |
| rx_ide_i | input | 1 | Received extended-identifier flag |
| rx_rtr_i | input | 1 | Received remote flag |
| txd_valid_i | input | 1 | Transmit completion strobe |
| txd_idx_i | input | IDX_W | Index of the buffer that completed |
| rd_idx_i | input | IDX_W | Buffer index for the read port |
| rd_code_o | output | 4 | Code of the selected buffer |
| rd_id_o | output | 29 | Identifier of the selected buffer |
| rd_ide_o | output | 1 | Extended-identifier flag of the selected buffer |
| rd_rtr_o | output | 1 | Remote flag of the selected buffer |
| rd_dlc_o | output | 4 | Data length of the selected buffer |
| tx_pend_o | output | NUM_BUF | Pending-transmit vector, one bit per buffer |

## Verification
Two functions can land on the same buffer in the same cycle: the set from a finished scan and the clear from a transmit completion. To provoke this, the bench first makes an answer buffer pending. It then issues a second matching request and drives the completion strobe for that buffer on exactly the edge where the scan ends. The pending bit must still be set afterwards. A lone completion then clears it, and the buffer stays in the answer code.

// File: rtl/can_rr_pkg.sv
package can_rr_pkg;
  localparam int ID_W     = 29;
  localparam int STD_ID_W = 11;
  localparam int CODE_W   = 4;
  localparam int DLC_W    = 4;

  localparam logic [CODE_W-1:0] CODE_OFF      = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_RX_EMPTY = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_TX_IDLE  = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_TX_SEND  = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_TX_ANSW  = 4'b1010;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            ide;
  } rr_req_t;
endpackage

// File: rtl/can_rr_bank.sv
module can_rr_bank
  import can_rr_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cfg_we_i,
  input  logic [IDX_W-1:0]                 cfg_idx_i,
  input  logic [CODE_W-1:0]                cfg_code_i,
  input  logic [ID_W-1:0]                  cfg_id_i,
  input  logic                             cfg_ide_i,
  input  logic                             cfg_rtr_i,
  input  logic [DLC_W-1:0]                 cfg_dlc_i,
  input  logic                             txd_valid_i,
  input  logic [IDX_W-1:0]                 txd_idx_i,
  output logic [NUM_BUF-1:0][CODE_W-1:0]   code_o,
  output logic [NUM_BUF-1:0][ID_W-1:0]     id_o,
  output logic [NUM_BUF-1:0]               ide_o,
  output logic [NUM_BUF-1:0]               rtr_o,
  output logic [NUM_BUF-1:0][DLC_W-1:0]    dlc_o
);
  logic [NUM_BUF-1:0][CODE_W-1:0] code_q;
  logic [NUM_BUF-1:0][ID_W-1:0]   id_q;
  logic [NUM_BUF-1:0]             ide_q;
  logic [NUM_BUF-1:0]             rtr_q;
  logic [NUM_BUF-1:0][DLC_W-1:0]  dlc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      id_q   <= '0;
      ide_q  <= '0;
      rtr_q  <= '0;
      dlc_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (cfg_we_i && cfg_idx_i == IDX_W'(i)) begin
          code_q[i] <= cfg_code_i;
          id_q[i]   <= cfg_id_i;
          ide_q[i]  <= cfg_ide_i;
          rtr_q[i]  <= cfg_rtr_i;
          dlc_q[i]  <= cfg_dlc_i;
        end else if (txd_valid_i && txd_idx_i == IDX_W'(i) &&
                     code_q[i] == CODE_TX_SEND) begin
          // a sent remote request turns into a receiver for the answer
          code_q[i] <= rtr_q[i] ? CODE_RX_EMPTY : CODE_TX_IDLE;
        end
      end
    end
  end

  assign code_o = code_q;
  assign id_o   = id_q;
  assign ide_o  = ide_q;
  assign rtr_o  = rtr_q;
  assign dlc_o  = dlc_q;

  p_req_to_rx_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_valid_i && code_q[txd_idx_i] == CODE_TX_SEND && rtr_q[txd_idx_i] &&
     !(cfg_we_i && cfg_idx_i == txd_idx_i))
    |=> (code_q[$past(txd_idx_i)] == CODE_RX_EMPTY &&
         id_q[$past(txd_idx_i)] == $past(id_q[txd_idx_i])));

  p_data_to_idle_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_valid_i && code_q[txd_idx_i] == CODE_TX_SEND && !rtr_q[txd_idx_i] &&
     !(cfg_we_i && cfg_idx_i == txd_idx_i))
    |=> (code_q[$past(txd_idx_i)] == CODE_TX_IDLE));
endmodule

// File: rtl/can_rr_scan.sv
module can_rr_scan
  import can_rr_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rx_valid_i,
  input  logic [ID_W-1:0]                rx_id_i,
  input  logic                           rx_ide_i,
  input  logic                           rx_rtr_i,
  input  logic [NUM_BUF-1:0][CODE_W-1:0] code_i,
  input  logic [NUM_BUF-1:0][ID_W-1:0]   id_i,
  input  logic [NUM_BUF-1:0]             ide_i,
  output logic                           set_v_o,
  output logic [IDX_W-1:0]               set_idx_o
);
  localparam logic [ID_W-1:0]  STD_MASK = {{(ID_W-STD_ID_W){1'b0}}, {STD_ID_W{1'b1}}};
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUF-1);

  logic             busy_q, hit_q, hold_v_q;
  logic [IDX_W-1:0] idx_q, hit_idx_q;
  rr_req_t          cur_q, hold_q, rx_req;
  logic             accept, last, match, id_eq;
  logic [ID_W-1:0]  id_mask;

  assign rx_req  = '{id: rx_id_i, ide: rx_ide_i};
  assign accept  = rx_valid_i && rx_rtr_i;
  assign last    = busy_q && (idx_q == LAST_IDX);
  assign id_mask = cur_q.ide ? '1 : STD_MASK;
  assign id_eq   = ((id_i[idx_q] ^ cur_q.id) & id_mask) == '0;
  assign match   = busy_q && code_i[idx_q] == CODE_TX_ANSW &&
                   ide_i[idx_q] == cur_q.ide && id_eq;

  assign set_v_o   = last && (hit_q || match);
  assign set_idx_o = hit_q ? hit_idx_q : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      hit_q     <= 1'b0;
      hold_v_q  <= 1'b0;
      idx_q     <= '0;
      hit_idx_q <= '0;
      cur_q     <= '0;
      hold_q    <= '0;
    end else if (!busy_q) begin
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        hit_q  <= 1'b0;
        cur_q  <= rx_req;
      end
    end else if (last) begin
      idx_q <= '0;
      hit_q <= 1'b0;
      if (hold_v_q) begin
        cur_q    <= hold_q;
        hold_v_q <= accept;
        if (accept) hold_q <= rx_req;
      end else if (accept) begin
        cur_q <= rx_req;
      end else begin
        busy_q <= 1'b0;
      end
    end else begin
      idx_q <= idx_q + 1'b1;
      if (match && !hit_q) begin
        hit_q     <= 1'b1;
        hit_idx_q <= idx_q;
      end
      // one-entry holder; a request arriving while it is full is dropped
      if (accept && !hold_v_q) begin
        hold_v_q <= 1'b1;
        hold_q   <= rx_req;
      end
    end
  end

  p_hold_in_scan_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_v_q |-> busy_q);

  p_scan_steps_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/can_rr_pend.sv
module can_rr_pend
  import can_rr_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [CODE_W-1:0]   cfg_code_i,
  input  logic                set_v_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  input  logic                txd_valid_i,
  input  logic [IDX_W-1:0]    txd_idx_i,
  output logic [NUM_BUF-1:0]  pend_o
);
  logic [NUM_BUF-1:0] pend_q;

  // priority: configuration write, then scan hit, then completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (cfg_we_i && cfg_idx_i == IDX_W'(i))
          pend_q[i] <= (cfg_code_i == CODE_TX_SEND);
        else if (set_v_i && set_idx_i == IDX_W'(i))
          pend_q[i] <= 1'b1;
        else if (txd_valid_i && txd_idx_i == IDX_W'(i))
          pend_q[i] <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  p_cfg_send_sets_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_code_i == CODE_TX_SEND) |=> pend_q[$past(cfg_idx_i)]);

  p_hit_beats_done_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v_i && !(cfg_we_i && cfg_idx_i == set_idx_i)) |=> pend_q[$past(set_idx_i)]);

  p_done_clears_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_valid_i && !(set_v_i && set_idx_i == txd_idx_i) &&
     !(cfg_we_i && cfg_idx_i == txd_idx_i)) |=> !pend_q[$past(txd_idx_i)]);
endmodule

// File: rtl/can_remote_responder.sv
module can_remote_responder
  import can_rr_pkg::*;
#(
  parameter int NUM_BUF = 16,
  localparam int IDX_W  = (NUM_BUF > 2) ? $clog2(NUM_BUF) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [CODE_W-1:0]    cfg_code_i,
  input  logic [ID_W-1:0]      cfg_id_i,
  input  logic                 cfg_ide_i,
  input  logic                 cfg_rtr_i,
  input  logic [DLC_W-1:0]     cfg_dlc_i,
  input  logic                 rx_valid_i,
  input  logic [ID_W-1:0]      rx_id_i,
  input  logic                 rx_ide_i,
  input  logic                 rx_rtr_i,
  input  logic                 txd_valid_i,
  input  logic [IDX_W-1:0]     txd_idx_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [CODE_W-1:0]    rd_code_o,
  output logic [ID_W-1:0]      rd_id_o,
  output logic                 rd_ide_o,
  output logic                 rd_rtr_o,
  output logic [DLC_W-1:0]     rd_dlc_o,
  output logic [NUM_BUF-1:0]   tx_pend_o
);
  logic [NUM_BUF-1:0][CODE_W-1:0] code;
  logic [NUM_BUF-1:0][ID_W-1:0]   id;
  logic [NUM_BUF-1:0]             ide, rtr;
  logic [NUM_BUF-1:0][DLC_W-1:0]  dlc;
  logic                           set_v;
  logic [IDX_W-1:0]               set_idx;

  can_rr_bank #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_idx_i, .cfg_code_i, .cfg_id_i, .cfg_ide_i, .cfg_rtr_i, .cfg_dlc_i,
    .txd_valid_i, .txd_idx_i,
    .code_o(code), .id_o(id), .ide_o(ide), .rtr_o(rtr), .dlc_o(dlc)
  );

  can_rr_scan #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_scan (
    .clk_i, .rst_ni,
    .rx_valid_i, .rx_id_i, .rx_ide_i, .rx_rtr_i,
    .code_i(code), .id_i(id), .ide_i(ide),
    .set_v_o(set_v), .set_idx_o(set_idx)
  );

  can_rr_pend #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_pend (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_idx_i, .cfg_code_i,
    .set_v_i(set_v), .set_idx_i(set_idx),
    .txd_valid_i, .txd_idx_i,
    .pend_o(tx_pend_o)
  );

  assign rd_code_o = code[rd_idx_i];
  assign rd_id_o   = id[rd_idx_i];
  assign rd_ide_o  = ide[rd_idx_i];
  assign rd_rtr_o  = rtr[rd_idx_i];
  assign rd_dlc_o  = dlc[rd_idx_i];
endmodule

// File: tb/can_remote_responder_bench.sv
module can_remote_responder_bench;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_ide = 0, cfg_rtr = 0;
  logic [IW-1:0] cfg_idx = '0, txd_idx = '0, rd_idx = '0;
  logic [3:0] cfg_code = '0, cfg_dlc = '0;
  logic [28:0] cfg_id = '0, rx_id = '0;
  logic rx_valid = 0, rx_ide = 0, rx_rtr = 0, txd_valid = 0;
  logic [3:0] rd_code, rd_dlc;
  logic [28:0] rd_id;
  logic rd_ide, rd_rtr;
  logic [N-1:0] pend;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  can_remote_responder #(.NUM_BUF(N)) u_can_remote_responder (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_code_i(cfg_code), .cfg_id_i(cfg_id),
    .cfg_ide_i(cfg_ide), .cfg_rtr_i(cfg_rtr), .cfg_dlc_i(cfg_dlc),
    .rx_valid_i(rx_valid), .rx_id_i(rx_id), .rx_ide_i(rx_ide), .rx_rtr_i(rx_rtr),
    .txd_valid_i(txd_valid), .txd_idx_i(txd_idx), .rd_idx_i(rd_idx),
    .rd_code_o(rd_code), .rd_id_o(rd_id), .rd_ide_o(rd_ide), .rd_rtr_o(rd_rtr),
    .rd_dlc_o(rd_dlc), .tx_pend_o(pend)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(int idx, logic [3:0] code, logic [28:0] id, logic ide, logic rtr, logic [3:0] dlc);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_code = code; cfg_id = id;
    cfg_ide = ide; cfg_rtr = rtr; cfg_dlc = dlc;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // leaves the bench at the negedge after the sampling edge E0
  task automatic rx(logic [28:0] id, logic ide, logic rtr);
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_ide = ide; rx_rtr = rtr;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic txd(int idx);
    @(negedge clk);
    txd_valid = 1; txd_idx = IW'(idx);
    @(posedge clk);
    @(negedge clk);
    txd_valid = 0;
  endtask

  task automatic rd(int idx);
    rd_idx = IW'(idx);
    #1;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pend", 64'(pend), 64'(0));
    for (int i = 0; i < N; i++) begin
      rd(i);
      chk("R1 code", 64'(rd_code), 64'(0));
      chk("R1 id", 64'(rd_id), 64'(0));
    end
  endtask

  task automatic t_cfg_pend();
    do_reset();
    wr(3, 4'b1100, 29'h55, 0, 0, 4'd2);
    chk("R2 send sets", 64'(pend), 64'(1 << 3));
    wr(3, 4'b1000, 29'h55, 0, 0, 4'd2);
    chk("R2 idle clears", 64'(pend), 64'(0));
  endtask

  task automatic t_req_done();
    do_reset();
    wr(3, 4'b1100, 29'h1234567, 1, 1, 4'd0);
    txd(3);
    rd(3);
    chk("R3 code rx", 64'(rd_code), 64'(4'b0100));
    chk("R3 id kept", 64'(rd_id), 64'(29'h1234567));
    chk("R3 pend clr", 64'(pend), 64'(0));
    wr(4, 4'b1100, 29'h99, 0, 0, 4'd8);
    txd(4);
    rd(4);
    chk("R4 code idle", 64'(rd_code), 64'(4'b1000));
  endtask

  task automatic t_match();
    do_reset();
    wr(5, 4'b1010, 29'h123, 0, 0, 4'd6);
    wr(6, 4'b1010, 29'h124, 0, 0, 4'd3);
    wr(7, 4'b0100, 29'h123, 0, 0, 4'd1);
    rx(29'h123, 0, 1);
    cyc(N - 1);
    chk("R5 not early", 64'(pend), 64'(0));
    cyc(1);
    chk("R5 hit", 64'(pend), 64'(1 << 5));
    rd(5);
    chk("R8 dlc kept", 64'(rd_dlc), 64'(6));
    chk("R8 rtr data", 64'(rd_rtr), 64'(0));
    rd(7);
    chk("R6 rx buf untouched", 64'({rd_code, rd_dlc}), 64'({4'b0100, 4'd1}));
  endtask

  task automatic t_nomatch();
    do_reset();
    wr(1, 4'b1000, 29'h200, 0, 0, 4'd2);
    wr(2, 4'b0100, 29'h200, 0, 0, 4'd2);
    wr(3, 4'b1010, 29'h201, 0, 0, 4'd2);
    rx(29'h200, 0, 1);
    cyc(N + 2);
    chk("R6 no pend", 64'(pend), 64'(0));
    rd(1);
    chk("R6 idle kept", 64'(rd_code), 64'(4'b1000));
    rd(2);
    chk("R6 rx kept", 64'(rd_code), 64'(4'b0100));
  endtask

  task automatic t_ide();
    do_reset();
    wr(8, 4'b1010, 29'h1ABCD123, 1, 0, 4'd4);
    wr(9, 4'b1010, 29'h055, 0, 0, 4'd4);
    rx(29'h1ABCD123, 0, 1);
    cyc(N + 1);
    chk("R12 ide differs", 64'(pend), 64'(0));
    rx(29'h0000855, 0, 1);
    cyc(N);
    chk("R12 std low bits", 64'(pend), 64'(1 << 9));
    rx(29'h1ABCD123, 1, 1);
    cyc(N);
    chk("R12 ext full", 64'(pend), 64'((1 << 9) | (1 << 8)));
  endtask

  task automatic t_lowest();
    do_reset();
    wr(10, 4'b1010, 29'h3AA, 0, 0, 4'd1);
    wr(3, 4'b1010, 29'h3AA, 0, 1, 4'd5);
    wr(12, 4'b1010, 29'h3AA, 0, 0, 4'd1);
    rx(29'h3AA, 0, 1);
    cyc(N);
    chk("R7 lowest only", 64'(pend), 64'(1 << 3));
    rd(3);
    chk("R8 remote answer", 64'(rd_rtr), 64'(1));
    chk("R8 own dlc", 64'(rd_dlc), 64'(5));
  endtask

  task automatic t_data_ignored();
    do_reset();
    wr(2, 4'b1010, 29'h77, 0, 0, 4'd1);
    rx(29'h77, 0, 0);
    cyc(N + 2);
    chk("R9 data frame", 64'(pend), 64'(0));
  endtask

  task automatic t_hold();
    do_reset();
    wr(1, 4'b1010, 29'h11, 0, 0, 4'd1);
    wr(2, 4'b1010, 29'h22, 0, 0, 4'd1);
    wr(4, 4'b1010, 29'h44, 0, 0, 4'd1);
    rx(29'h11, 0, 1);   // E0
    rx(29'h22, 0, 1);   // E1, held
    rx(29'h44, 0, 1);   // E2, dropped
    cyc(N - 3);
    chk("R10 first", 64'(pend), 64'(1 << 1));
    cyc(N);
    chk("R10 held", 64'(pend), 64'((1 << 1) | (1 << 2)));
    cyc(N + 2);
    chk("R10 dropped", 64'(pend), 64'((1 << 1) | (1 << 2)));
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(6, 4'b1010, 29'h66, 0, 0, 4'd2);
    rx(29'h66, 0, 1);
    cyc(N);
    chk("R11 pre", 64'(pend), 64'(1 << 6));
    rx(29'h66, 0, 1);
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    txd_valid = 1; txd_idx = IW'(6);
    @(posedge clk);   // scan end and completion together
    @(negedge clk);
    txd_valid = 0;
    chk("R11 set wins", 64'(pend), 64'(1 << 6));
    txd(6);
    chk("R11 lone clear", 64'(pend), 64'(0));
    rd(6);
    chk("R11 answer kept", 64'(rd_code), 64'(4'b1010));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cfg_pend();
    t_req_done();
    t_match();
    t_nomatch();
    t_ide();
    t_lowest();
    t_data_ignored();
    t_hold();
    t_same_cycle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule